// File: doc/BRIEF.md
# Byte-Order Emulation Address Adjuster

This unit sits after address translation and before the memory port. It makes a memory with one fixed byte order look like the other byte order. It does this by XOR-ing the low bits of the real address with a constant that depends on the access size. Only the address changes. The data lanes are never swapped.

At a synchronisation strobe the unit compares the requested little-endian mode with the native byte order of the memory. It then computes one XOR constant per access size and holds the whole set in a register until the next strobe. Each access sends an address, a size code and a class flag. Instruction fetches and page-table walks set the class flag, and such accesses always use the word constant. The adjusted address comes out one cycle later.

The unit has two error outputs:
- A size error, raised when the size code is not one of the four defined codes.
- An order error, raised when byte-order emulation is disabled and software asks for the foreign byte order.

Top module: `endx_addr_unit`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid_o`, `rsp_size_err_o`, `order_err_o` and `rsp_addr_o` are zero. Until the first strobe, every access passes its address through unchanged.
- R2: If `le_mode_i` equals `native_le_i` when `sync_i` is high, every later access leaves the address unchanged, whatever its size code.
- R3: If `le_mode_i` differs from `native_le_i` and `swap_en_i` is 1 when `sync_i` is high, later accesses XOR address bits [2:0] as follows. Size code 0 (1 byte) uses 7, code 1 (2 bytes) uses 6, code 2 (4 bytes) uses 4, and code 3 (8 bytes) uses 0. Bits above bit 2 are never changed.
- R4: An access with `req_fixed_i` = 1 (instruction fetch or page-table walk) uses the word constant: 4 when swapping is active, otherwise 0. Its size code is ignored and no size error is raised.
- R5: Changes on `le_mode_i`, `native_le_i` or `swap_en_i` while `sync_i` is low have no effect on later accesses.
- R6: An access in the same cycle as `sync_i` uses the constants captured at the previous strobe. The new constants apply from the next cycle on.
- R7: If `swap_en_i` = 0 and the mode disagrees with the native order when `sync_i` is high, `order_err_o` is 1 from the next cycle and the constants are all zero. `order_err_o` clears at the next strobe with no conflict.
- R8: An access with `req_fixed_i` = 0 and size code 4 to 7 gives `rsp_size_err_o` = 1 and the address unchanged.
- R9: `rsp_valid_o` equals `req_valid_i` of the previous cycle. `rsp_addr_o` and `rsp_size_err_o` belong to that request. While no request is present, `rsp_addr_o` holds and `rsp_size_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Strobe that captures a new set of XOR constants |
| le_mode_i | input | 1 | Requested byte order: 1 = little-endian |
| native_le_i | input | 1 | Native memory byte order: 1 = little-endian |
| swap_en_i | input | 1 | 1 = emulation of the foreign byte order allowed |
| req_valid_i | input | 1 | Access present |
| req_size_i | input | 3 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes; 4 to 7 invalid |
| req_fixed_i | input | 1 | Instruction fetch or page-table access (word constant) |
| req_addr_i | input | AW (32) | Translated real address |
| rsp_valid_o | output | 1 | Adjusted address valid |
| rsp_addr_o | output | AW (32) | Adjusted real address |
| rsp_size_err_o | output | 1 | Invalid size code on this response |
| order_err_o | output | 1 | Byte-order change refused because swapping is disabled |

## Verification
A strobe and an access can fall in the same cycle, and so can a strobe and a byte-order refusal. The bench provokes the first case by raising `sync_i` together with a request while the mode flips. That response must carry the old constant, and the next response must carry the new one. The second case is provoked by a strobe with swapping disabled and a mismatched mode, with an access in the same cycle. That access must keep its old constant, and the refusal must show together with the zero constants from the next cycle on. A behavioural model captures its own mode at each strobe and predicts every output on every clock.

// File: rtl/endx_pkg.sv
package endx_pkg;

    // Size codes (the bench and the requirements rely on these values)
    localparam int unsigned SZ_BYTE  = 0;
    localparam int unsigned SZ_HALF  = 1;
    localparam int unsigned SZ_WORD  = 2;
    localparam int unsigned SZ_DWORD = 3;

    // XOR constant for an access of 2**k bytes inside a 2**gl-byte granule
    function automatic int unsigned endx_lane_flip(int unsigned gl, int unsigned k);
        int unsigned full;
        full = (32'd1 << gl) - 32'd1;
        return (full << k) & full;
    endfunction

endpackage

// File: rtl/endx_mask_gen.sv
module endx_mask_gen #(
    parameter int unsigned GRAN_LOG2 = 3,
    localparam int unsigned NSZ = GRAN_LOG2 + 1
) (
    input  logic                              flip_i,
    output logic [NSZ-1:0][GRAN_LOG2-1:0]     masks_o
);
    import endx_pkg::*;

    for (genvar k = 0; k < NSZ; k++) begin : g_size
        localparam int unsigned FLIP = endx_lane_flip(GRAN_LOG2, k);
        assign masks_o[k] = flip_i ? GRAN_LOG2'(FLIP) : '0;
    end

endmodule

// File: rtl/endx_lane_sel.sv
module endx_lane_sel #(
    parameter int unsigned GRAN_LOG2  = 3,
    parameter int unsigned FETCH_LOG2 = 2,
    localparam int unsigned NSZ = GRAN_LOG2 + 1,
    localparam int unsigned SZW = $clog2(NSZ) + 1
) (
    input  logic [NSZ-1:0][GRAN_LOG2-1:0] masks_i,
    input  logic [SZW-1:0]                size_i,
    input  logic                          fixed_i,
    output logic [GRAN_LOG2-1:0]          mask_o,
    output logic                          size_err_o
);

    always_comb begin
        mask_o     = '0;
        size_err_o = 1'b0;
        if (fixed_i) begin
            mask_o = masks_i[FETCH_LOG2];
        end else if (32'(size_i) < NSZ) begin
            mask_o = masks_i[size_i[$clog2(NSZ)-1:0]];
        end else begin
            size_err_o = 1'b1;
        end
    end

endmodule

// File: rtl/endx_addr_unit.sv
module endx_addr_unit #(
    parameter int unsigned AW         = 32,
    parameter int unsigned GRAN_LOG2  = 3,
    parameter int unsigned FETCH_LOG2 = 2,
    localparam int unsigned NSZ = GRAN_LOG2 + 1,
    localparam int unsigned SZW = $clog2(NSZ) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_i,
    input  logic          le_mode_i,
    input  logic          native_le_i,
    input  logic          swap_en_i,
    input  logic          req_valid_i,
    input  logic [2:0]    req_size_i,
    input  logic          req_fixed_i,
    input  logic [AW-1:0] req_addr_i,
    output logic          rsp_valid_o,
    output logic [AW-1:0] rsp_addr_o,
    output logic          rsp_size_err_o,
    output logic          order_err_o
);

    typedef struct packed {
        logic [NSZ-1:0][GRAN_LOG2-1:0] table_;
        logic                          order_err;
        logic                          valid;
        logic [AW-1:0]                 addr;
        logic                          size_err;
    } state_t;

    state_t state_d, state_q;

    logic                          mismatch;
    logic                          flip;
    logic [NSZ-1:0][GRAN_LOG2-1:0] new_masks;
    logic [GRAN_LOG2-1:0]          sel_mask;
    logic                          sel_err;

    assign mismatch = le_mode_i ^ native_le_i;
    assign flip     = mismatch & swap_en_i;

    endx_mask_gen #(.GRAN_LOG2(GRAN_LOG2)) u_gen (
        .flip_i  (flip),
        .masks_o (new_masks)
    );

    endx_lane_sel #(.GRAN_LOG2(GRAN_LOG2), .FETCH_LOG2(FETCH_LOG2)) u_sel (
        .masks_i    (state_q.table_),
        .size_i     (SZW'(req_size_i)),
        .fixed_i    (req_fixed_i),
        .mask_o     (sel_mask),
        .size_err_o (sel_err)
    );

    always_comb begin
        state_d          = state_q;
        state_d.valid    = req_valid_i;
        state_d.size_err = 1'b0;
        if (sync_i) begin
            state_d.table_    = new_masks;
            state_d.order_err = mismatch & ~swap_en_i;
        end
        if (req_valid_i) begin
            state_d.addr     = req_addr_i ^ AW'(sel_mask);
            state_d.size_err = sel_err;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rsp_valid_o    = state_q.valid;
    assign rsp_addr_o     = state_q.addr;
    assign rsp_size_err_o = state_q.size_err;
    assign order_err_o    = state_q.order_err;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o);  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o && !rsp_size_err_o);  // R9
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_addr_o[AW-1:GRAN_LOG2] == $past(req_addr_i[AW-1:GRAN_LOG2]));  // R3
    AST_BAD_SIZE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !req_fixed_i && req_size_i >= 3'(NSZ)
        |=> rsp_size_err_o && rsp_addr_o == $past(req_addr_i));  // R8
    AST_FIXED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_fixed_i |=> !rsp_size_err_o);  // R4
    AST_HOLD_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> $stable(state_q.table_));  // R5
    AST_MATCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i && (le_mode_i == native_le_i) |=> state_q.table_ == '0);  // R2
    AST_REFUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        order_err_o |-> state_q.table_ == '0);  // R7

endmodule

// File: tb/endx_addr_unit_test.sv
module endx_addr_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_i = 1'b0;
    logic        le_mode_i = 1'b0;
    logic        native_le_i = 1'b0;
    logic        swap_en_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [2:0]  req_size_i = 3'd0;
    logic        req_fixed_i = 1'b0;
    logic [31:0] req_addr_i = 32'd0;
    logic        rsp_valid_o;
    logic [31:0] rsp_addr_o;
    logic        rsp_size_err_o;
    logic        order_err_o;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    endx_addr_unit uut (
        .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .le_mode_i(le_mode_i),
        .native_le_i(native_le_i), .swap_en_i(swap_en_i),
        .req_valid_i(req_valid_i), .req_size_i(req_size_i),
        .req_fixed_i(req_fixed_i), .req_addr_i(req_addr_i),
        .rsp_valid_o(rsp_valid_o), .rsp_addr_o(rsp_addr_o),
        .rsp_size_err_o(rsp_size_err_o), .order_err_o(order_err_o)
    );

    // Behavioural reference model
    bit          m_flip = 0;
    bit          e_oerr = 0;
    bit          e_valid = 0;
    bit [31:0]   e_addr = 0;
    bit          e_err = 0;

    function automatic int unsigned flip_const(bit f, int unsigned sz, bit fx);
        if (!f) return 0;
        if (fx) return 4;
        case (sz)
            0: return 7;
            1: return 6;
            2: return 4;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flip = 0; e_oerr = 0; e_valid = 0; e_addr = 0; e_err = 0;
        end else begin
            e_valid = req_valid_i;
            e_err   = 0;
            if (req_valid_i) begin
                e_err  = !req_fixed_i && req_size_i > 3;
                e_addr = req_addr_i ^ flip_const(m_flip, req_size_i, req_fixed_i);
            end
            if (sync_i) begin
                m_flip = (le_mode_i != native_le_i) && swap_en_i;
                e_oerr = (le_mode_i != native_le_i) && !swap_en_i;
            end
        end
    end

    task automatic check(bit ok, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check(rsp_valid_o == e_valid, "valid", rsp_valid_o, e_valid);
        check(rsp_addr_o == e_addr, "addr", rsp_addr_o, e_addr);
        check(rsp_size_err_o == e_err, "size_err", rsp_size_err_o, e_err);
        check(order_err_o == e_oerr, "order_err", order_err_o, e_oerr);
    end

    task automatic step(bit s, bit v, int unsigned sz, bit fx, logic [31:0] a);
        @(negedge clk);
        sync_i = s; req_valid_i = v; req_size_i = 3'(sz); req_fixed_i = fx; req_addr_i = a;
    endtask

    task automatic sweep(logic [31:0] base);
        for (int s = 0; s < 4; s++) step(0, 1, s, 0, base + 32'(s));
        step(0, 1, 0, 1, base);
    endtask

    bit done = 0;

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0x1 expected=0x0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep(32'h1234_5670);              // R1: before any strobe, pass-through
        cur_req = "R2";
        le_mode_i = 1; native_le_i = 1; swap_en_i = 1;
        step(1, 0, 0, 0, 0);
        sweep(32'hABCD_EF00);
        cur_req = "R3";
        le_mode_i = 0;
        step(1, 0, 0, 0, 0);
        sweep(32'hFFFF_FFF8);
        sweep(32'h0000_0003);
        cur_req = "R4";
        for (int s = 0; s < 8; s++) step(0, 1, s, 1, 32'h8000_0011 + 32'(s));
        cur_req = "R8";
        for (int s = 4; s < 8; s++) step(0, 1, s, 0, 32'h5555_5555 + 32'(s));
        cur_req = "R5";
        le_mode_i = 1; swap_en_i = 0; native_le_i = 0;
        sweep(32'h0000_1000);
        le_mode_i = 1; native_le_i = 1;
        sweep(32'h0000_2000);
        cur_req = "R6";
        le_mode_i = 0; native_le_i = 1; swap_en_i = 1;
        step(1, 1, 0, 0, 32'h0000_3000);
        step(0, 1, 0, 0, 32'h0000_3000);
        le_mode_i = 1;
        step(1, 1, 1, 0, 32'h0000_3101);
        step(0, 1, 1, 0, 32'h0000_3101);
        cur_req = "R7";
        le_mode_i = 0; swap_en_i = 1;
        step(1, 0, 0, 0, 0);
        swap_en_i = 0;
        step(1, 1, 0, 0, 32'h0000_4000);
        sweep(32'h0000_4100);
        le_mode_i = 1;
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        cur_req = "R9";
        step(0, 1, 2, 0, 32'hDEAD_BEEF);
        repeat (3) step(0, 0, 3, 0, 32'h1111_1111);
        step(0, 1, 5, 0, 32'h2222_2222);
        step(0, 0, 5, 0, 32'h3333_3333);
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        rst_n = 1'b1;
        sweep(32'h0000_0007);
        step(0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule